// File: doc/BRIEF.md
# Multi-Rail Power Sequencer Supervisor

This controller brings up a display supply's three rails in a fixed order. It first enables the reference. It then enables the main boost rail, then the negative charge-pump rail, then the positive charge-pump rail. A rail is switched on only after every rail ahead of it has been judged regulated by its power-good comparator flag. Each rail runs a soft-start window and a fault-timeout window, and each window is a parameter counted in clock ticks. The main rail and the two auxiliary rails take separate lengths for both windows.

Once all rails are regulated, the active-low ready output goes low. After that, a dropped power-good flag raises ready again and switches off every rail later in the order. Those later rails restart by themselves when the faulted rail recovers. A rail that never reaches regulation within its timeout is latched off, and so are the rails after it.

Three inputs force the block back to idle: a low shutdown pin, the undervoltage-lockout flag, and the over-temperature flag. While any of them is asserted, every output is off. The sequence starts again from the beginning once all three are released.

Top module: `rail_sequencer`

## Requirements
- R1: After reset, and while idle, `ref_en`, `rail_en` and `ss_active` are all 0 and `ready_n` is 1.
- R2: One clock after the hold condition clears, `ref_en` is 1. Rail 0 (main) is enabled on the following clock.
- R3: Rail i (bit i of `rail_en`, with 0 = main, 1 = negative, 2 = positive) is enabled only while every rail j < i is regulated and its synchronized power-good is 1. It is enabled one clock after that condition first holds.
- R4: `ss_active[i]` is 1 from the clock in which rail i is enabled, for SS ticks. SS is `SS_MAIN` for rail 0 and `SS_AUX` for the others. It ends early in the clock where the rail is judged regulated.
- R5: A rising `pg_raw[i]` is seen by the rail's state machine through a two-flop synchronizer. The rail is judged regulated on the third rising clock edge after the input changes.
- R6: `ready_n` goes to 0 one clock after every rail is regulated with synchronized power-good 1. It returns to 1 on the clock that follows any synchronized power-good drop.
- R7: When a regulated rail's power-good drops, every later rail is disabled on the same clock. The rail itself stays enabled. Once it recovers, the later rails re-run their start steps.
- R8: `shdn_n` = 0 turns off all outputs on the next clock edge. Setting it back to 1 restarts the sequence from R2.
- R9: `uvlo` = 1 or `otemp` = 1 acts like shutdown. The block stays idle until both flags are 0.
- R10: A rail whose power-good has not been seen after TO ticks of being enabled is latched off. TO is `TO_MAIN` for rail 0 and `TO_AUX` for the others. It and all later rails stay off, and ready stays 1, until a hold condition occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; all timers count its rising edges |
| rst_n | input | 1 | Asynchronous active-low reset |
| shdn_n | input | 1 | Active-low shutdown request |
| uvlo | input | 1 | Input-supply undervoltage flag, active high |
| otemp | input | 1 | Over-temperature flag, active high |
| pg_raw | input | N_RAIL | Asynchronous power-good comparator flags, one per rail |
| ref_en | output | 1 | Reference enable |
| rail_en | output | N_RAIL | Per-rail enable |
| ss_active | output | N_RAIL | Per-rail soft-start-in-progress flag |
| ready_n | output | 1 | Active-low all-rails-ready indication |

## Verification
Two events can fall in the same cycle. A rail's soft-start window can open in the very clock where its synchronized power-good is already high. A predecessor's fault can also remove a rail's permission in the clock where that rail would be judged regulated. The bench provokes the first case by restarting from shutdown with every power-good input already high. It expects each rail's soft-start flag to last exactly one clock and each next rail to follow two clocks later. It provokes the second case by dropping the main rail's power-good while later rails are regulated. It expects both later rails off on one edge, not a cascade.

// File: rtl/rseq_pkg.sv
package rseq_pkg;
   typedef enum logic [1:0] {
      RS_OFF  = 2'd0,
      RS_RAMP = 2'd1,
      RS_ON   = 2'd2,
      RS_TRIP = 2'd3
   } rail_st_e;
endpackage

// File: rtl/rseq_sync.sv
module rseq_sync #(
   parameter int W      = 3,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] chain [STAGES];

   generate
      if (STAGES < 2) begin : g_bad
         $error("rseq_sync needs at least two stages");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) chain[s] <= '0;
      end else begin
         chain[0] <= d;
         for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/rseq_rail.sv
module rseq_rail
   import rseq_pkg::*;
#(
   parameter int SS_LEN = 8,
   parameter int TO_LEN = 20
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hold,
   input  logic permit,
   input  logic pg,
   output logic en,
   output logic ss_on,
   output logic regulated
);
   localparam int TW = $clog2(TO_LEN + 1);
   localparam logic [TW-1:0] TO_LAST = TW'(TO_LEN - 1);
   localparam logic [TW-1:0] SS_END  = TW'(SS_LEN);

   generate
      if (SS_LEN < 1 || TO_LEN <= SS_LEN) begin : g_bad
         $error("rseq_rail: timeout must exceed a nonzero soft-start");
      end
   endgenerate

   rail_st_e       st;
   logic [TW-1:0]  tmr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st  <= RS_OFF;
         tmr <= '0;
      end else if (hold) begin
         st  <= RS_OFF;
         tmr <= '0;
      end else begin
         unique case (st)
            RS_OFF: begin
               if (permit) begin
                  st  <= RS_RAMP;
                  tmr <= '0;
               end
            end
            RS_RAMP: begin
               if (!permit)            st <= RS_OFF;
               else if (pg)            st <= RS_ON;
               else if (tmr == TO_LAST) st <= RS_TRIP;
               else                    tmr <= tmr + 1'b1;
            end
            RS_ON: begin
               if (!permit) st <= RS_OFF;
            end
            RS_TRIP: st <= RS_TRIP;
            default: st <= RS_OFF;
         endcase
      end
   end

   assign en        = (st == RS_RAMP) || (st == RS_ON);
   assign ss_on     = (st == RS_RAMP) && (tmr < SS_END);
   assign regulated = (st == RS_ON);
endmodule

// File: rtl/rail_sequencer.sv
module rail_sequencer #(
   parameter int N_RAIL  = 3,
   parameter int SS_MAIN = 14000,
   parameter int SS_AUX  = 3500,
   parameter int TO_MAIN = 55000,
   parameter int TO_AUX  = 14000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              shdn_n,
   input  logic              uvlo,
   input  logic              otemp,
   input  logic [N_RAIL-1:0] pg_raw,
   output logic              ref_en,
   output logic [N_RAIL-1:0] rail_en,
   output logic [N_RAIL-1:0] ss_active,
   output logic              ready_n
);
   generate
      if (N_RAIL < 2) begin : g_bad
         $error("rail_sequencer needs at least two rails");
      end
   endgenerate

   logic              hold;
   logic [N_RAIL-1:0] pg_s;
   logic [N_RAIL-1:0] reg_ok;
   logic [N_RAIL:0]   chain_ok;
   logic              ref_q;
   logic              rdy_n_q;

   assign hold = !shdn_n || uvlo || otemp;

   rseq_sync #(.W(N_RAIL), .STAGES(2)) u_pg_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pg_raw),
      .q     (pg_s)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ref_q <= 1'b0;
      else        ref_q <= !hold;
   end

   assign chain_ok[0] = ref_q;

   for (genvar i = 0; i < N_RAIL; i++) begin : g_rail
      localparam int SS_I = (i == 0) ? SS_MAIN : SS_AUX;
      localparam int TO_I = (i == 0) ? TO_MAIN : TO_AUX;

      rseq_rail #(.SS_LEN(SS_I), .TO_LEN(TO_I)) u_rail (
         .clk       (clk),
         .rst_n     (rst_n),
         .hold      (hold),
         .permit    (chain_ok[i]),
         .pg        (pg_s[i]),
         .en        (rail_en[i]),
         .ss_on     (ss_active[i]),
         .regulated (reg_ok[i])
      );

      assign chain_ok[i+1] = chain_ok[i] && reg_ok[i] && pg_s[i];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    rdy_n_q <= 1'b1;
      else if (hold) rdy_n_q <= 1'b1;
      else           rdy_n_q <= !chain_ok[N_RAIL];
   end

   assign ref_en  = ref_q;
   assign ready_n = rdy_n_q;
endmodule

// File: rtl/rseq_chk.sv
module rseq_chk #(
   parameter int N = 3
) (
   input logic         clk,
   input logic         rst_n,
   input logic         shdn_n,
   input logic         uvlo,
   input logic         otemp,
   input logic         ref_en,
   input logic [N-1:0] rail_en,
   input logic [N-1:0] ss_active,
   input logic         ready_n
);
   // R1
   ref_gates_rails_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ref_en |-> (rail_en == '0));

   for (genvar i = 1; i < N; i++) begin : g_ord
      // R3
      rail_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
         rail_en[i] |-> rail_en[i-1]);
   end

   // R4
   ss_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ss_active & ~rail_en) == '0);

   // R6
   ready_all_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ready_n |-> (&rail_en && ss_active == '0));

   // R8
   hold_kills_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!shdn_n || uvlo || otemp) |=> (!ref_en && rail_en == '0 && ready_n));
endmodule

bind rail_sequencer rseq_chk #(.N(N_RAIL)) u_rseq_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .shdn_n    (shdn_n),
   .uvlo      (uvlo),
   .otemp     (otemp),
   .ref_en    (ref_en),
   .rail_en   (rail_en),
   .ss_active (ss_active),
   .ready_n   (ready_n)
);

// File: tb/tb_rail_sequencer.sv
`timescale 1ns/1ps
module tb_rail_sequencer;
   localparam int N = 3;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         shdn_n = 1'b0;
   logic         uvlo = 1'b0;
   logic         otemp = 1'b0;
   logic [N-1:0] pg_raw = '0;
   logic         ref_en;
   logic [N-1:0] rail_en;
   logic [N-1:0] ss_active;
   logic         ready_n;

   always #4 clk = ~clk;

   rail_sequencer #(
      .N_RAIL(N), .SS_MAIN(8), .SS_AUX(4), .TO_MAIN(20), .TO_AUX(10)
   ) dut (
      .clk(clk), .rst_n(rst_n), .shdn_n(shdn_n), .uvlo(uvlo), .otemp(otemp),
      .pg_raw(pg_raw), .ref_en(ref_en), .rail_en(rail_en),
      .ss_active(ss_active), .ready_n(ready_n)
   );

   typedef struct {
      string      req;
      logic [7:0] exp;
   } item_t;

   item_t q[$];
   event  chk_ev;
   int    n_chk  = 0;
   int    n_fail = 0;
   bit    done   = 1'b0;

   function automatic logic [7:0] pk(logic r, logic [2:0] e, logic [2:0] s, logic rd);
      return {r, e, s, rd};
   endfunction

   task automatic expect_out(string req, logic r, logic [2:0] e, logic [2:0] s, logic rd);
      item_t it;
      it.req = req;
      it.exp = pk(r, e, s, rd);
      q.push_back(it);
      -> chk_ev;
      #0;
   endtask

   task automatic tick(int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   initial begin : monitor
      forever begin
         @(chk_ev);
         while (q.size() > 0) begin
            item_t it;
            logic [7:0] act;
            it  = q.pop_front();
            act = {ref_en, rail_en, ss_active, ready_n};
            n_chk++;
            if (act !== it.exp) begin
               n_fail++;
               $display("FAIL %s: {ref,en,ss,rdy_n} actual=%b expected=%b", it.req, act, it.exp);
            end
         end
      end
   end

   initial begin : watchdog
      #(200000 * 8);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin : driver
      tick(3);
      expect_out("R1 reset", 0, 3'b000, 3'b000, 1);
      rst_n = 1'b1;
      tick(2);
      expect_out("R1 idle with shdn low", 0, 3'b000, 3'b000, 1);

      // startup walk
      shdn_n = 1'b1;
      tick(1);
      expect_out("R2 reference first", 1, 3'b000, 3'b000, 1);
      tick(1);
      expect_out("R2 main rail next", 1, 3'b001, 3'b001, 1);
      tick(7);
      expect_out("R4 main soft-start last tick", 1, 3'b001, 3'b001, 1);
      tick(1);
      expect_out("R4 main soft-start elapsed", 1, 3'b001, 3'b000, 1);
      expect_out("R3 negative waits for main", 1, 3'b001, 3'b000, 1);
      pg_raw[0] = 1'b1;
      tick(2);
      expect_out("R5 not yet regulated after two edges", 1, 3'b001, 3'b000, 1);
      tick(1);
      expect_out("R5 regulated on third edge", 1, 3'b001, 3'b000, 1);
      tick(1);
      expect_out("R3 negative enabled", 1, 3'b011, 3'b010, 1);
      tick(3);
      expect_out("R4 aux soft-start last tick", 1, 3'b011, 3'b010, 1);
      tick(1);
      expect_out("R4 aux soft-start elapsed", 1, 3'b011, 3'b000, 1);
      pg_raw[1] = 1'b1;
      tick(3);
      expect_out("R3 positive waits a clock", 1, 3'b011, 3'b000, 1);
      tick(1);
      expect_out("R3 positive enabled", 1, 3'b111, 3'b100, 1);
      pg_raw[2] = 1'b1;
      tick(3);
      expect_out("R6 ready one clock after regulation", 1, 3'b111, 3'b000, 1);
      tick(1);
      expect_out("R6 ready asserted", 1, 3'b111, 3'b000, 0);

      // fault on negative rail after ready
      pg_raw[1] = 1'b0;
      tick(2);
      expect_out("R6 ready held through sync", 1, 3'b111, 3'b000, 0);
      tick(1);
      expect_out("R7 later rail off, ready released", 1, 3'b011, 3'b000, 1);
      pg_raw[1] = 1'b1;
      tick(3);
      expect_out("R7 positive restarts", 1, 3'b111, 3'b100, 1);
      tick(2);
      expect_out("R7 ready after restart", 1, 3'b111, 3'b000, 0);

      // fault on main rail: both later rails drop together
      pg_raw[0] = 1'b0;
      tick(3);
      expect_out("R7 main fault drops both later rails", 1, 3'b001, 3'b000, 1);

      // shutdown and restart with all pg already high
      pg_raw[0] = 1'b1;
      shdn_n = 1'b0;
      tick(1);
      expect_out("R8 shutdown clears all", 0, 3'b000, 3'b000, 1);
      shdn_n = 1'b1;
      tick(1);
      expect_out("R8 restart reference", 1, 3'b000, 3'b000, 1);
      tick(1);
      expect_out("R4 one-tick soft-start with pg high", 1, 3'b001, 3'b001, 1);
      tick(1);
      expect_out("R4 soft-start ended by pg", 1, 3'b001, 3'b000, 1);
      tick(5);
      expect_out("R8 full restart ready", 1, 3'b111, 3'b000, 0);

      // undervoltage then over-temperature
      uvlo = 1'b1;
      tick(1);
      expect_out("R9 uvlo forces idle", 0, 3'b000, 3'b000, 1);
      uvlo = 1'b0;
      otemp = 1'b1;
      tick(2);
      expect_out("R9 otemp keeps idle", 0, 3'b000, 3'b000, 1);
      otemp = 1'b0;
      tick(1);
      expect_out("R9 restart after flags clear", 1, 3'b000, 3'b000, 1);

      // timeout latch on negative rail
      shdn_n = 1'b0;
      pg_raw = 3'b001;
      tick(1);
      shdn_n = 1'b1;
      tick(4);
      expect_out("R10 negative rail ramping", 1, 3'b011, 3'b010, 1);
      tick(9);
      expect_out("R10 still enabled at last timeout tick", 1, 3'b011, 3'b000, 1);
      tick(1);
      expect_out("R10 latched off at timeout", 1, 3'b001, 3'b000, 1);
      pg_raw = 3'b111;
      tick(5);
      expect_out("R10 latch ignores recovered pg", 1, 3'b001, 3'b000, 1);
      shdn_n = 1'b0;
      tick(1);
      shdn_n = 1'b1;
      tick(8);
      expect_out("R10 latch cleared by shutdown", 1, 3'b111, 3'b000, 0);

      tick(1);
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule